// File: doc/BRIEF.md
# Fetch-Hijack Takeover Controller

This controller sits on a cartridge slot and gives a handler program control of the CPU without using an interrupt line. A request input arms it. The next opcode fetch from the slot is then taken over. The normal RAM is switched off for that fetch and the fetch address is latched. In place of the RAM data, the controller returns a three-byte absolute jump (opcode 0xC3, then the low and the high byte of `HANDLER_ADDR`) on three consecutive slot reads. After the last jump byte, handler memory is mapped into the slot.

While the handler runs, it can read the latched return address from two register locations. It signals completion by writing to a third register location. It then jumps back to the latched address. The controller watches for the opcode fetch at that exact address, gives the slot back to the RAM from the first cycle of that fetch, and pulses `done`.

The state machine has seven states:
- ST_IDLE: moves to ST_ARMED on `req`.
- ST_ARMED: moves to ST_INJECT_OP at the start of a slot opcode fetch.
- ST_INJECT_OP: moves to ST_INJECT_LO at the end of that read.
- ST_INJECT_LO: moves to ST_INJECT_HI at the end of the next slot read.
- ST_INJECT_HI: moves to ST_HANDLER at the end of the slot read after that.
- ST_HANDLER: moves to ST_RESTORE when the done register is written.
- ST_RESTORE: moves to ST_IDLE at the start of the opcode fetch whose address matches the latched one.

Top module: `m1_inject_ctrl`

## Requirements
- R1: After reset the block is in ST_IDLE with `ram_en`=1, `hmem_sel`=0, `dout_en`=0, `done`=0 and `busy`=0.
- R2: While the block is idle, `req`=1 at a clock edge moves it to ST_ARMED, and `busy` is 1 from then on. While `busy` is 1, `req` has no effect.
- R3: While armed, only a read access that begins with `sltsel_n`, `rd_n` and `m1_n` all low starts a takeover. Other slot reads, writes, and fetches with `sltsel_n` high keep `ram_en`=1 and `dout_en`=0.
- R4: From the first cycle of the triggering fetch, `ram_en`=0 and `dout_en`=1 with `dout`=0xC3. The fetch address is latched.
- R5: The next two slot reads, whatever the value of `m1_n`, return the low byte and then the high byte of `HANDLER_ADDR` with `dout_en`=1. Writes in between do not advance the sequence. `ram_en` stays 0 throughout.
- R6: Once the high-byte read ends, `hmem_sel`=1 and `ram_en`=0.
- R7: In ST_HANDLER and ST_RESTORE, a slot read at `REG_BASE` returns the low byte of the latched address and a slot read at `REG_BASE`+1 returns the high byte. Both reads give `dout_en`=1 and `hmem_sel`=0.
- R8: In ST_HANDLER, a slot write to `REG_BASE`+2 enters ST_RESTORE. The memory mapping does not change.
- R9: In ST_RESTORE, a slot opcode fetch at the latched address sees `ram_en`=1 and `hmem_sel`=0 from its first cycle. `done` is 1 for exactly one cycle and `busy` falls. Opcode fetches at any other address stay in handler memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address bus |
| sltsel_n | input | 1 | Slot select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch indicator, active low |
| req | input | 1 | Takeover request |
| dout | output | 8 | Data driven toward the CPU |
| dout_en | output | 1 | Enable for `dout` |
| ram_en | output | 1 | Enable for the normal RAM |
| hmem_sel | output | 1 | Select for handler memory |
| busy | output | 1 | A takeover is in progress |
| done | output | 1 | One-cycle pulse when control is returned |

## Verification
The bench checks the first cycle of the triggering fetch. A design that switched the RAM off one clock late would show `ram_en`=1 there. It also raises `req` while an access is already under way, which must not inject into that access. A design that armed on the level of the strobes instead of the access start would serve 0xC3 to a plain read.

During the handler, the bench makes opcode fetches at addresses other than the return address. A controller that gave the slot back on any opcode fetch would hand the slot to RAM while the handler's own jump is being fetched. Writes between the jump bytes are also checked, because a design that counted every access would skip the high byte.

// File: rtl/m1_inject_pkg.sv
package m1_inject_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] JP_OPCODE = 8'hC3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_INJECT_OP,
        ST_INJECT_LO,
        ST_INJECT_HI,
        ST_HANDLER,
        ST_RESTORE
    } inj_state_t;
endpackage

// File: rtl/m1_bus_watch.sv
module m1_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic sltsel_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_act,
    output logic rd_start,
    output logic rd_end,
    output logic wr_start
);
    logic rd_act_q;
    logic wr_act;
    logic wr_act_q;

    assign rd_act   = !sltsel_n && !rd_n;
    assign wr_act   = !sltsel_n && !wr_n;
    assign rd_start = rd_act && !rd_act_q;
    assign rd_end   = !rd_act && rd_act_q;
    assign wr_start = wr_act && !wr_act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
        end
    end

    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);
endmodule

// File: rtl/m1_ret_latch.sv
module m1_ret_latch
    import m1_inject_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] ret_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr <= '0;
        end else if (capture) begin
            ret_addr <= addr;
        end
    end

    a_r4_latch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ret_addr == $past(addr));
endmodule

// File: rtl/m1_seq_fsm.sv
module m1_seq_fsm
    import m1_inject_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_DONE = 16'h7FF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              m1_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              rd_start,
    input  logic              rd_end,
    input  logic              wr_start,
    output inj_state_t        state,
    output logic              trig,
    output logic              reen,
    output logic              done
);
    inj_state_t next_state;
    logic       fetch_start;

    assign fetch_start = rd_start && !m1_n;
    assign trig = (state == ST_ARMED) && fetch_start;
    assign reen = (state == ST_RESTORE) && fetch_start && (addr == ret_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= next_state;
            done  <= reen;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:      if (req) next_state = ST_ARMED;
            ST_ARMED:     if (trig) next_state = ST_INJECT_OP;
            ST_INJECT_OP: if (rd_end) next_state = ST_INJECT_LO;
            ST_INJECT_LO: if (rd_end) next_state = ST_INJECT_HI;
            ST_INJECT_HI: if (rd_end) next_state = ST_HANDLER;
            ST_HANDLER:   if (wr_start && addr == REG_DONE) next_state = ST_RESTORE;
            ST_RESTORE:   if (reen) next_state = ST_IDLE;
        endcase
    end

    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req) |=> state == ST_ARMED);
    a_r5_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT_LO && rd_end) |=> state == ST_INJECT_HI);
    a_r8_restore_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESTORE && !$stable(state)) |-> $past(state) == ST_HANDLER);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == ST_RESTORE);
endmodule

// File: rtl/m1_out_drive.sv
module m1_out_drive
    import m1_inject_pkg::*;
#(
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 16'h4010,
    parameter logic [ADDR_W-1:0] REG_LO       = 16'h7FF0,
    parameter logic [ADDR_W-1:0] REG_HI       = 16'h7FF1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  inj_state_t        state,
    input  logic              trig,
    input  logic              reen,
    input  logic              rd_act,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ret_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              ram_en,
    output logic              hmem_sel
);
    always_comb begin
        dout     = '0;
        dout_en  = 1'b0;
        ram_en   = 1'b1;
        hmem_sel = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ARMED: begin
                if (trig) begin
                    ram_en  = 1'b0;
                    dout_en = 1'b1;
                    dout    = JP_OPCODE;
                end
            end
            ST_INJECT_OP: begin
                ram_en = 1'b0;
                if (rd_act) begin
                    dout_en = 1'b1;
                    dout    = JP_OPCODE;
                end
            end
            ST_INJECT_LO: begin
                ram_en = 1'b0;
                if (rd_act) begin
                    dout_en = 1'b1;
                    dout    = HANDLER_ADDR[DATA_W-1:0];
                end
            end
            ST_INJECT_HI: begin
                ram_en = 1'b0;
                if (rd_act) begin
                    dout_en = 1'b1;
                    dout    = HANDLER_ADDR[ADDR_W-1:DATA_W];
                end
            end
            ST_HANDLER, ST_RESTORE: begin
                if (!reen) begin
                    ram_en   = 1'b0;
                    hmem_sel = 1'b1;
                    if (rd_act && addr == REG_LO) begin
                        hmem_sel = 1'b0;
                        dout_en  = 1'b1;
                        dout     = ret_addr[DATA_W-1:0];
                    end else if (rd_act && addr == REG_HI) begin
                        hmem_sel = 1'b0;
                        dout_en  = 1'b1;
                        dout     = ret_addr[ADDR_W-1:DATA_W];
                    end
                end
            end
        endcase
    end

    a_r5_ram_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT_OP || state == ST_INJECT_LO || state == ST_INJECT_HI) |-> !ram_en);
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(hmem_sel && dout_en));
    a_r6_handler_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HANDLER) |-> !ram_en && (hmem_sel || dout_en));
endmodule

// File: rtl/m1_inject_ctrl.sv
module m1_inject_ctrl
    import m1_inject_pkg::*;
#(
    parameter logic [15:0] HANDLER_ADDR = 16'h4010,
    parameter logic [15:0] REG_BASE     = 16'h7FF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic        sltsel_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        m1_n,
    input  logic        req,
    output logic [7:0]  dout,
    output logic        dout_en,
    output logic        ram_en,
    output logic        hmem_sel,
    output logic        busy,
    output logic        done
);
    localparam logic [15:0] REG_LO   = REG_BASE;
    localparam logic [15:0] REG_HI   = REG_BASE + 16'd1;
    localparam logic [15:0] REG_DONE = REG_BASE + 16'd2;

    logic       rd_act, rd_start, rd_end, wr_start;
    logic       trig, reen;
    logic [15:0] ret_addr;
    inj_state_t state;

    m1_bus_watch u_watch (
        .clk(clk), .rst_n(rst_n), .sltsel_n(sltsel_n), .rd_n(rd_n), .wr_n(wr_n),
        .rd_act(rd_act), .rd_start(rd_start), .rd_end(rd_end), .wr_start(wr_start)
    );

    m1_seq_fsm #(.REG_DONE(REG_DONE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .m1_n(m1_n), .addr(addr),
        .ret_addr(ret_addr), .rd_start(rd_start), .rd_end(rd_end),
        .wr_start(wr_start), .state(state), .trig(trig), .reen(reen), .done(done)
    );

    m1_ret_latch u_latch (
        .clk(clk), .rst_n(rst_n), .capture(trig), .addr(addr), .ret_addr(ret_addr)
    );

    m1_out_drive #(
        .HANDLER_ADDR(HANDLER_ADDR), .REG_LO(REG_LO), .REG_HI(REG_HI)
    ) u_drive (
        .clk(clk), .rst_n(rst_n), .state(state), .trig(trig), .reen(reen),
        .rd_act(rd_act), .addr(addr), .ret_addr(ret_addr), .dout(dout),
        .dout_en(dout_en), .ram_en(ram_en), .hmem_sel(hmem_sel)
    );

    assign busy = (state != ST_IDLE);

    a_r9_ram_back: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ram_en && !hmem_sel);
endmodule

// File: tb/m1_inject_ctrl_test.sv
module m1_inject_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] HADDR = 16'h4010;
    localparam logic [15:0] RBASE = 16'h7FF0;
    localparam int S_IDLE = 0, S_ARMED = 1, S_OP = 2, S_LO = 3, S_HI = 4, S_HND = 5, S_RST = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic sltsel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1, req = 1'b0;
    logic [7:0] dout;
    logic dout_en, ram_en, hmem_sel, busy, done;

    int checks = 0;
    int errors = 0;
    int mstate = S_IDLE;
    logic [15:0] mret = '0;
    logic mdone = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    m1_inject_ctrl #(.HANDLER_ADDR(HADDR), .REG_BASE(RBASE)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sltsel_n(sltsel_n), .rd_n(rd_n),
        .wr_n(wr_n), .m1_n(m1_n), .req(req), .dout(dout), .dout_en(dout_en),
        .ram_en(ram_en), .hmem_sel(hmem_sel), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected outputs {dout_en, dout, ram_en, hmem_sel} from the spec.
    function automatic logic [10:0] exp_out(input int st, input logic [15:0] a,
                                            input logic rd, input logic m1, input logic first);
        logic den = 0, ram = 1, hs = 0;
        logic [7:0] d = 0;
        case (st)
            S_ARMED: if (rd && m1 && first) begin ram = 0; den = 1; d = 8'hC3; end
            S_OP: begin ram = 0; if (rd) begin den = 1; d = 8'hC3; end end
            S_LO: begin ram = 0; if (rd) begin den = 1; d = HADDR[7:0]; end end
            S_HI: begin ram = 0; if (rd) begin den = 1; d = HADDR[15:8]; end end
            S_HND, S_RST: begin
                if (!(st == S_RST && rd && m1 && first && a == mret)) begin
                    ram = 0; hs = 1;
                    if (rd && a == RBASE) begin hs = 0; den = 1; d = mret[7:0]; end
                    else if (rd && a == RBASE + 16'd1) begin hs = 0; den = 1; d = mret[15:8]; end
                end
            end
            default: ;
        endcase
        return {den, d, ram, hs};
    endfunction

    task automatic cmp(input string tag, input logic [10:0] e);
        chk({tag, " dout_en"}, dout_en, e[10]);
        if (e[10]) chk({tag, " dout"}, dout, e[9:2]);
        chk({tag, " ram_en"}, ram_en, e[1]);
        chk({tag, " hmem_sel"}, hmem_sel, e[0]);
    endtask

    task automatic access(input string tag, input logic [15:0] a, input logic is_rd,
                          input logic m1, input logic sel);
        @(negedge clk);
        addr = a; sltsel_n = !sel; rd_n = !is_rd; wr_n = is_rd; m1_n = !m1;
        #1 cmp({tag, " first"}, exp_out(mstate, a, is_rd && sel, m1, 1'b1));
        @(posedge clk);
        mdone = 0;
        if (mstate == S_IDLE && req) mstate = S_ARMED;
        else if (sel && is_rd && m1 && mstate == S_ARMED) begin mstate = S_OP; mret = a; end
        else if (sel && is_rd && m1 && mstate == S_RST && a == mret) begin mstate = S_IDLE; mdone = 1; end
        else if (sel && !is_rd && mstate == S_HND && a == RBASE + 16'd2) mstate = S_RST;
        #1 cmp({tag, " held"}, exp_out(mstate, a, is_rd && sel, m1, 1'b0));
        chk({tag, " done R9"}, done, mdone);
        chk({tag, " busy R2"}, busy, mstate != S_IDLE);
        @(negedge clk);
        sltsel_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
        @(posedge clk);
        mdone = 0;
        if (mstate == S_IDLE && req) mstate = S_ARMED;
        else if (sel && is_rd && mstate == S_OP) mstate = S_LO;
        else if (sel && is_rd && mstate == S_LO) mstate = S_HI;
        else if (sel && is_rd && mstate == S_HI) mstate = S_HND;
        #1 chk({tag, " done off R9"}, done, 1'b0);
        chk({tag, " busy after R2"}, busy, mstate != S_IDLE);
        cmp({tag, " after R6"}, exp_out(mstate, a, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic idle(input logic r);
        @(negedge clk);
        req = r;
        @(posedge clk);
        if (mstate == S_IDLE && req) mstate = S_ARMED;
        #1 chk("idle busy R2", busy, mstate != S_IDLE);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20191004));
        repeat (3) @(posedge clk);
        #1;
        cmp("reset R1", {1'b0, 8'h00, 1'b1, 1'b0});
        chk("reset done R1", done, 1'b0);
        chk("reset busy R1", busy, 1'b0);
        @(negedge clk);
        rst_n = 1;
        idle(1'b0);
        // R3: fetch while not armed is plain RAM
        access("unarmed fetch R3", 16'h0100, 1'b1, 1'b1, 1'b1);
        idle(1'b1);
        idle(1'b0);
        access("armed plain read R3", 16'h2000, 1'b1, 1'b0, 1'b1);
        access("armed write R3", 16'h2001, 1'b0, 1'b0, 1'b1);
        access("armed fetch unselected R3", 16'h2002, 1'b1, 1'b1, 1'b0);
        access("trigger R4", 16'h1234, 1'b1, 1'b1, 1'b1);
        access("lo byte R5", 16'h1235, 1'b1, 1'b0, 1'b1);
        access("write between R5", 16'h1236, 1'b0, 1'b0, 1'b1);
        access("hi byte R5", 16'h1236, 1'b1, 1'b0, 1'b1);
        access("handler fetch R6", HADDR, 1'b1, 1'b1, 1'b1);
        access("ret lo R7", RBASE, 1'b1, 1'b0, 1'b1);
        access("ret hi R7", RBASE + 16'd1, 1'b1, 1'b0, 1'b1);
        idle(1'b1);
        access("req busy ignored R2", HADDR + 16'd1, 1'b1, 1'b1, 1'b1);
        idle(1'b0);
        access("done write R8", RBASE + 16'd2, 1'b0, 1'b0, 1'b1);
        access("handler jump fetch R9", HADDR + 16'd5, 1'b1, 1'b1, 1'b1);
        access("ret read in restore R7", RBASE, 1'b1, 1'b0, 1'b1);
        access("return fetch R9", 16'h1234, 1'b1, 1'b1, 1'b1);
        chk("return address model R4", mret, 16'h1234);
        // R2: req raised during an access must not inject into it
        @(negedge clk);
        addr = 16'h3000; sltsel_n = 0; rd_n = 0; m1_n = 0;
        req = 1;
        @(posedge clk);
        #1 chk("mid-access req ram_en R2", ram_en, 1'b1);
        chk("mid-access req dout_en R2", dout_en, 1'b0);
        @(negedge clk);
        sltsel_n = 1; rd_n = 1; m1_n = 1; req = 0;
        mstate = S_ARMED;
        @(posedge clk);
        access("late trigger R4", 16'hBEEF, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 9);
            logic [15:0] a = 16'($urandom);
            if (mstate == S_HND && k < 3) a = RBASE + 16'd2;
            else if (mstate == S_RST && k < 5) a = mret;
            else if (k == 9) a = RBASE + 16'($urandom_range(0, 1));
            if (k == 8) idle(($urandom_range(0, 3) == 0));
            else access("random", a, ($urandom_range(0, 3) != 0),
                        ($urandom_range(0, 1) == 1), ($urandom_range(0, 7) != 0));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule